// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block stores incoming packets into a packet memory that is divided into 256-byte pages. A page number is the upper byte of a 16-bit byte address, and the low byte is the offset inside the page. Received bytes arrive on a simple stream with start, valid, end and status signals. Each packet is placed in a run of adjacent pages of a ring. The ring begins at a programmable first page and ends just before a programmable stop page. When the page after the last one would equal the stop page, the ring wraps to the first page.

A current page register marks where the next packet will go. A boundary page, owned by the host, marks the oldest page the host has not yet read. Packet data starts at offset 4 of the current page. The block writes a 4-byte header into offsets 0 to 3 only after the end of the packet is known, and only then moves the current page forward. Whenever the block needs a new page, it compares that page with the boundary first. A match means the page holds unread data, so the block drops the packet, leaves the current page unchanged, and raises an overwrite warning as a pulse and as a sticky status bit.

The controller is a state machine with these states:
- IDLE waits for a start byte.
- DATA stores bytes.
- DROP discards the rest of an aborted packet.
- FIN checks the page that would follow the packet.
- HDR0 to HDR3 write the header.

It has these transitions:
- IDLE goes to DATA on a start byte, or to FIN when that byte is also the last one.
- DATA goes to FIN on the end byte. It goes to DROP, or to IDLE if the end byte is the one that hits, when a page advance hits the boundary.
- DROP goes to IDLE on the end byte.
- FIN goes to IDLE on a boundary hit, or otherwise to HDR0.
- HDR0 steps through to HDR3, and HDR3 goes to IDLE, committing the packet.

Top module: `rx_page_ring`

## Requirements
- R1: After reset, mem_we, pkt_done, ovw_pulse and ovw_flag are 0, and cur_page is 0x00.
- R2: A cur_set pulse in IDLE, with no start byte in the same cycle, loads cur_set_page into cur_page. The new value is visible after the next clock edge.
- R3: The first byte of a packet (rx_valid and rx_sop) is written at address {cur_page, 0x04}. Later bytes go to consecutive offsets. Every write address has a page in the range [first_page, stop_page).
- R4: When a page fills at offset 0xFF, the next byte goes to offset 0x00 of the following page. The following page is page+1, except that page+1 equal to stop_page is replaced by first_page.
- R5: After the last byte, the header is written at offsets 0x00 to 0x03 of the packet's first page, in the order 0, 1, 2, 3:
  - byte 0 is rx_status as sampled with rx_eop;
  - byte 1 is the next-packet page, which is the page after the last page used, with the wrap of R4;
  - bytes 2 and 3 are the length, low byte first; the length counts the data bytes plus 4.
- R6: cur_page takes the next-packet page in the same cycle as a one-cycle pkt_done pulse, which comes with the write of header byte 3. It changes at no other time except by R2.
- R7: If the page needed for the next byte equals bnd_page, that byte and the rest of the packet are not written, and no header is written. cur_page keeps its value, and ovw_pulse rises for one cycle. Bytes up to rx_eop are dropped.
- R8: If the next-packet page of a fully stored packet equals bnd_page, no header is written, cur_page keeps its value, and ovw_pulse rises for one cycle.
- R9: ovw_flag is set together with ovw_pulse. It stays set, even across later good packets, until an ovw_clr pulse clears it.
- R10: ring_empty is 1 exactly when the page after bnd_page, with the wrap of R4, equals cur_page.
- R11: In IDLE, bytes with rx_valid high and rx_sop low cause no write and no change of cur_page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| first_page | input | 8 | First page of the ring |
| stop_page | input | 8 | Page just past the end of the ring |
| bnd_page | input | 8 | Host boundary page (oldest unread page) |
| cur_set | input | 1 | Load pulse for the current page |
| cur_set_page | input | 8 | Value loaded by cur_set |
| ovw_clr | input | 1 | Clears the overwrite status bit |
| rx_valid | input | 1 | Byte valid on rx_data |
| rx_sop | input | 1 | First byte of a packet |
| rx_eop | input | 1 | Last byte of a packet |
| rx_data | input | 8 | Received byte |
| rx_status | input | 8 | Receive status, sampled with rx_eop |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address {page, offset} |
| mem_wdata | output | 8 | Memory write data |
| cur_page | output | 8 | Current (write) page register |
| pkt_done | output | 1 | One-cycle pulse when a packet is committed |
| ovw_pulse | output | 1 | One-cycle pulse when a packet is dropped for overwrite |
| ovw_flag | output | 1 | Sticky overwrite status bit |
| ring_empty | output | 1 | Ring holds no unread packet |

## Verification
A data byte taken at a clock edge shows on the memory port right after that edge, so it is due one cycle after it is driven. The header bytes follow the end byte by two to five cycles, and pkt_done and the new cur_page appear together with header byte 3. A boundary hit raises ovw_pulse one cycle after the byte or FIN cycle that caused it. The scoreboard compares memory writes in order, whenever mem_we is seen at a falling edge, against items the driver pushed from a model of the requirements. Pointer, pulse-count, flag and empty checks are made only after ten idle cycles, which is well past the latest due cycle.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int HDR_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DATA = 3'd1,
        ST_DROP = 3'd2,
        ST_FIN  = 3'd3,
        ST_HDR0 = 3'd4,
        ST_HDR1 = 3'd5,
        ST_HDR2 = 3'd6,
        ST_HDR3 = 3'd7
    } rxr_state_e;

endpackage

// File: rtl/rxr_page_step.sv
// Ring page advance with wrap, plus equality against a reference page.
module rxr_page_step #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [PAGE_W-1:0] first_page,
    input  logic [PAGE_W-1:0] stop_page,
    input  logic [PAGE_W-1:0] ref_page,
    output logic [PAGE_W-1:0] next_page,
    output logic              hit
);
    logic [PAGE_W-1:0] inc;

    always_comb begin
        inc       = page + PAGE_W'(1);
        next_page = (inc == stop_page) ? first_page : inc;
        hit       = (next_page == ref_page);
    end
endmodule

// File: rtl/rxr_hdr_sel.sv
// Picks one byte of the packet header by index.
module rxr_hdr_sel #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic [1:0]        idx,
    input  logic [DATA_W-1:0] status,
    input  logic [PAGE_W-1:0] link_page,
    input  logic [LEN_W-1:0]  len,
    output logic [DATA_W-1:0] hdr_byte
);
    localparam int LEN_PAD = 2 * DATA_W;

    logic [LEN_PAD-1:0] len_ext;

    always_comb begin
        len_ext = LEN_PAD'(len);
        unique case (idx)
            2'd0: hdr_byte = status;
            2'd1: hdr_byte = DATA_W'(link_page);
            2'd2: hdr_byte = len_ext[DATA_W-1:0];
            2'd3: hdr_byte = len_ext[LEN_PAD-1:DATA_W];
            default: hdr_byte = '0;
        endcase
    end
endmodule

// File: rtl/rxr_ovw_flag.sv
// Sticky overwrite status bit; set wins over clear.
module rxr_ovw_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_page_ring.sv
module rx_page_ring
    import rxr_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PAGE_W-1:0]       first_page,
    input  logic [PAGE_W-1:0]       stop_page,
    input  logic [PAGE_W-1:0]       bnd_page,
    input  logic                    cur_set,
    input  logic [PAGE_W-1:0]       cur_set_page,
    input  logic                    ovw_clr,
    input  logic                    rx_valid,
    input  logic                    rx_sop,
    input  logic                    rx_eop,
    input  logic [DATA_W-1:0]       rx_data,
    input  logic [DATA_W-1:0]       rx_status,
    output logic                    mem_we,
    output logic [PAGE_W+OFF_W-1:0] mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic [PAGE_W-1:0]       cur_page,
    output logic                    pkt_done,
    output logic                    ovw_pulse,
    output logic                    ovw_flag,
    output logic                    ring_empty
);
    localparam int ADDR_W = PAGE_W + OFF_W;
    localparam logic [OFF_W-1:0] DATA_OFF  = OFF_W'(HDR_BYTES);
    localparam logic [LEN_W-1:0] FIRST_LEN = LEN_W'(HDR_BYTES + 1);

    rxr_state_e state_q, state_d;

    logic [PAGE_W-1:0] cur_q;
    logic [PAGE_W-1:0] start_pg_q;
    logic [PAGE_W-1:0] wpage_q;
    logic [OFF_W-1:0]  woff_q;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] status_q;
    logic [PAGE_W-1:0] link_q;

    logic [PAGE_W-1:0] step_next;
    logic              step_hit;
    logic [PAGE_W-1:0] bnd_next;
    logic              empty_hit;
    logic [1:0]        hdr_idx;
    logic [DATA_W-1:0] hdr_byte;

    logic              wr_en_c;
    logic [ADDR_W-1:0] wr_addr_c;
    logic [DATA_W-1:0] wr_data_c;
    logic              abort_c;
    logic              commit_c;
    logic              start_c;
    logic              take_c;
    logic              page_full;

    // Advance of the page being written, checked against the boundary.
    rxr_page_step #(.PAGE_W(PAGE_W)) u_wr_step (
        .page       (wpage_q),
        .first_page (first_page),
        .stop_page  (stop_page),
        .ref_page   (bnd_page),
        .next_page  (step_next),
        .hit        (step_hit)
    );

    // Page after the boundary, checked against the current page.
    rxr_page_step #(.PAGE_W(PAGE_W)) u_empty_step (
        .page       (bnd_page),
        .first_page (first_page),
        .stop_page  (stop_page),
        .ref_page   (cur_q),
        .next_page  (bnd_next),
        .hit        (empty_hit)
    );

    rxr_hdr_sel #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_hdr (
        .idx       (hdr_idx),
        .status    (status_q),
        .link_page (link_q),
        .len       (len_q),
        .hdr_byte  (hdr_byte)
    );

    rxr_ovw_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (abort_c),
        .clr   (ovw_clr),
        .flag  (ovw_flag)
    );

    assign page_full = (woff_q == '0);

    always_comb begin
        unique case (state_q)
            ST_HDR0: hdr_idx = 2'd0;
            ST_HDR1: hdr_idx = 2'd1;
            ST_HDR2: hdr_idx = 2'd2;
            ST_HDR3: hdr_idx = 2'd3;
            default: hdr_idx = 2'd0;
        endcase
    end

    // Next state and write-port decode.
    always_comb begin
        state_d   = state_q;
        wr_en_c   = 1'b0;
        wr_addr_c = {wpage_q, woff_q};
        wr_data_c = rx_data;
        abort_c   = 1'b0;
        commit_c  = 1'b0;
        start_c   = 1'b0;
        take_c    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_valid && rx_sop) begin
                    start_c   = 1'b1;
                    wr_en_c   = 1'b1;
                    wr_addr_c = {cur_q, DATA_OFF};
                    state_d   = rx_eop ? ST_FIN : ST_DATA;
                end
            end
            ST_DATA: begin
                if (rx_valid) begin
                    if (page_full && step_hit) begin
                        abort_c = 1'b1;
                        state_d = rx_eop ? ST_IDLE : ST_DROP;
                    end else begin
                        take_c    = 1'b1;
                        wr_en_c   = 1'b1;
                        wr_addr_c = {(page_full ? step_next : wpage_q), woff_q};
                        if (rx_eop) begin
                            state_d = ST_FIN;
                        end
                    end
                end
            end
            ST_DROP: begin
                if (rx_valid && rx_eop) begin
                    state_d = ST_IDLE;
                end
            end
            ST_FIN: begin
                if (step_hit) begin
                    abort_c = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_HDR0;
                end
            end
            ST_HDR0, ST_HDR1, ST_HDR2, ST_HDR3: begin
                wr_en_c   = 1'b1;
                wr_addr_c = {start_pg_q, OFF_W'(hdr_idx)};
                wr_data_c = hdr_byte;
                unique case (state_q)
                    ST_HDR0: state_d = ST_HDR1;
                    ST_HDR1: state_d = ST_HDR2;
                    ST_HDR2: state_d = ST_HDR3;
                    default: begin
                        state_d  = ST_IDLE;
                        commit_c = 1'b1;
                    end
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Packet tracking registers and the current page pointer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            start_pg_q <= '0;
            wpage_q    <= '0;
            woff_q     <= '0;
            len_q      <= '0;
            status_q   <= '0;
            link_q     <= '0;
        end else begin
            if (start_c) begin
                start_pg_q <= cur_q;
                wpage_q    <= cur_q;
                woff_q     <= DATA_OFF + OFF_W'(1);
                len_q      <= FIRST_LEN;
                if (rx_eop) begin
                    status_q <= rx_status;
                end
            end else if (take_c) begin
                if (page_full) begin
                    wpage_q <= step_next;
                end
                woff_q <= woff_q + OFF_W'(1);
                len_q  <= len_q + LEN_W'(1);
                if (rx_eop) begin
                    status_q <= rx_status;
                end
            end
            if (state_q == ST_FIN && !step_hit) begin
                link_q <= step_next;
            end
            if (commit_c) begin
                cur_q <= link_q;
            end else if (state_q == ST_IDLE && cur_set && !start_c) begin
                cur_q <= cur_set_page;
            end
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            pkt_done  <= 1'b0;
            ovw_pulse <= 1'b0;
        end else begin
            mem_we    <= wr_en_c;
            mem_addr  <= wr_addr_c;
            mem_wdata <= wr_data_c;
            pkt_done  <= commit_c;
            ovw_pulse <= abort_c;
        end
    end

    assign cur_page   = cur_q;
    assign ring_empty = empty_hit;

    logic unused_ok;
    assign unused_ok = ^bnd_next;

endmodule

// File: rtl/rx_page_ring_chk.sv
module rx_page_ring_chk #(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [PAGE_W-1:0]       first_page,
    input logic [PAGE_W-1:0]       stop_page,
    input logic                    cur_set,
    input logic                    mem_we,
    input logic [PAGE_W+OFF_W-1:0] mem_addr,
    input logic [PAGE_W-1:0]       cur_page,
    input logic                    pkt_done,
    input logic                    ovw_pulse,
    input logic                    ovw_flag
);
    // R3: writes stay inside the ring
    a_r3_addr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[PAGE_W+OFF_W-1:OFF_W] >= first_page &&
                    mem_addr[PAGE_W+OFF_W-1:OFF_W] <  stop_page));

    // R5: commit coincides with the write of header byte 3
    a_r5_done_with_hdr3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (mem_we && mem_addr[OFF_W-1:0] == OFF_W'(3)));

    // R6: pointer moves only on commit or host load
    a_r6_cur_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_done && !$past(cur_set)) |-> $stable(cur_page));

    // R6: commit pulse lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    // R7: a drop never coincides with a commit
    a_r7_no_done_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_done && ovw_pulse));

    // R8: a drop leaves the pointer alone
    a_r8_drop_keeps_cur: assert property (@(posedge clk) disable iff (!rst_n)
        ovw_pulse |-> $stable(cur_page));

    // R9: the pulse always leaves the sticky bit set
    a_r9_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ovw_pulse |-> ovw_flag);
endmodule

bind rx_page_ring rx_page_ring_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .first_page (first_page),
    .stop_page  (stop_page),
    .cur_set    (cur_set),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .cur_page   (cur_page),
    .pkt_done   (pkt_done),
    .ovw_pulse  (ovw_pulse),
    .ovw_flag   (ovw_flag)
);

// File: tb/test_rx_page_ring.sv
module test_rx_page_ring;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  first_page = 8'h4C;
    logic [7:0]  stop_page = 8'h80;
    logic [7:0]  bnd_page = 8'h7F;
    logic        cur_set = 1'b0;
    logic [7:0]  cur_set_page = 8'h00;
    logic        ovw_clr = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_sop = 1'b0;
    logic        rx_eop = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic [7:0]  rx_status = 8'h00;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  cur_page;
    logic        pkt_done;
    logic        ovw_pulse;
    logic        ovw_flag;
    logic        ring_empty;

    always #5 clk = ~clk;

    rx_page_ring i_rx_page_ring (
        .clk(clk), .rst_n(rst_n), .first_page(first_page), .stop_page(stop_page),
        .bnd_page(bnd_page), .cur_set(cur_set), .cur_set_page(cur_set_page),
        .ovw_clr(ovw_clr), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
        .rx_data(rx_data), .rx_status(rx_status), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .cur_page(cur_page), .pkt_done(pkt_done),
        .ovw_pulse(ovw_pulse), .ovw_flag(ovw_flag), .ring_empty(ring_empty)
    );

    int checks = 0;
    int fails = 0;
    int done_cnt = 0;
    int ovw_cnt = 0;
    bit finished = 1'b0;
    logic [23:0] exp_q[$];
    string       tag_q[$];
    logic [23:0] exp_item;
    string       exp_tag;
    logic [7:0]  exp_cur;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each memory write with the next expected item.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pkt_done) done_cnt++;
            if (ovw_pulse) ovw_cnt++;
            if (mem_we) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R11 unexpected write actual=0x%0h expected=none",
                             {mem_addr, mem_wdata});
                end else begin
                    exp_item = exp_q.pop_front();
                    exp_tag  = tag_q.pop_front();
                    if ({mem_addr, mem_wdata} !== exp_item) begin
                        fails++;
                        $display("FAIL %s write actual=0x%0h expected=0x%0h",
                                 exp_tag, {mem_addr, mem_wdata}, exp_item);
                    end
                end
            end
        end
    end

    function automatic logic [7:0] ring_step(input logic [7:0] p);
        logic [7:0] n;
        n = p + 8'd1;
        return (n == stop_page) ? first_page : n;
    endfunction

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 7 + seed) & 255);
    endfunction

    // Driver: pushes the expected writes from the requirement model, then drives the bytes.
    task automatic send_pkt(input int n, input logic [7:0] status, input int seed);
        logic [7:0] pg;
        logic [7:0] nx;
        int         off;
        bit         ab;
        logic [15:0] len;
        pg  = exp_cur;
        off = 4;
        ab  = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (off == 256) begin
                nx = ring_step(pg);
                if (nx == bnd_page) begin
                    ab = 1'b1;
                    break;
                end
                pg  = nx;
                off = 0;
            end
            exp_q.push_back({pg, 8'(off), pat(i, seed)});
            tag_q.push_back((pg == exp_cur) ? "R3" : "R4");
            off++;
        end
        if (!ab) begin
            nx = ring_step(pg);
            if (nx == bnd_page) begin
                ab = 1'b1;
            end else begin
                len = 16'(n + 4);
                exp_q.push_back({exp_cur, 8'h00, status});
                exp_q.push_back({exp_cur, 8'h01, nx});
                exp_q.push_back({exp_cur, 8'h02, len[7:0]});
                exp_q.push_back({exp_cur, 8'h03, len[15:8]});
                repeat (4) tag_q.push_back("R5");
                exp_cur = nx;
            end
        end
        for (int i = 0; i < n; i++) begin
            rx_valid  = 1'b1;
            rx_sop    = (i == 0);
            rx_eop    = (i == n - 1);
            rx_data   = pat(i, seed);
            rx_status = status;
            @(posedge clk); #1;
        end
        rx_valid = 1'b0;
        rx_sop   = 1'b0;
        rx_eop   = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_cur(input logic [7:0] p);
        @(posedge clk); #1;
        cur_set      = 1'b1;
        cur_set_page = p;
        @(posedge clk); #1;
        cur_set = 1'b0;
        exp_cur = p;
        @(negedge clk);
    endtask

    int d0, o0;

    initial begin
        exp_cur = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(mem_we == 1'b0 && pkt_done == 1'b0 && ovw_pulse == 1'b0, "R1 outputs", {mem_we, pkt_done, ovw_pulse}, 0);
        check(ovw_flag == 1'b0, "R1 flag", ovw_flag, 0);
        check(cur_page == 8'h00, "R1 cur_page", cur_page, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R2: host load; R10: empty when page after boundary is current
        load_cur(8'h4C);
        check(cur_page == 8'h4C, "R2 cur load", cur_page, 8'h4C);
        check(ring_empty == 1'b1, "R10 empty after load", ring_empty, 1);

        // R3 R5 R6: single-page packet
        d0 = done_cnt;
        send_pkt(10, 8'h01, 3);
        check(cur_page == exp_cur, "R6 cur after short pkt", cur_page, exp_cur);
        check(done_cnt - d0 == 1, "R6 done pulse", done_cnt - d0, 1);
        check(ring_empty == 1'b0, "R10 not empty", ring_empty, 0);

        // R4: chain over two pages
        send_pkt(300, 8'h21, 11);
        check(cur_page == 8'h4F, "R4 cur after chained pkt", cur_page, 8'h4F);

        // R4: wrap from the last ring page to the first
        bnd_page = 8'h70;
        load_cur(8'h7F);
        send_pkt(260, 8'h05, 29);
        check(cur_page == 8'h4D, "R4 cur after wrap", cur_page, 8'h4D);

        // R7: boundary hit in the middle of a packet
        bnd_page = 8'h4E;
        d0 = done_cnt; o0 = ovw_cnt;
        send_pkt(400, 8'h09, 41);
        check(cur_page == 8'h4D, "R7 cur kept", cur_page, 8'h4D);
        check(ovw_cnt - o0 == 1, "R7 ovw pulse", ovw_cnt - o0, 1);
        check(done_cnt - d0 == 0, "R7 no commit", done_cnt - d0, 0);
        check(ovw_flag == 1'b1, "R9 flag set", ovw_flag, 1);

        // R7: rest was dropped, next packet starts cleanly; R9 flag stays
        bnd_page = 8'h70;
        send_pkt(3, 8'h11, 53);
        check(cur_page == 8'h4E, "R7 recovery cur", cur_page, 8'h4E);
        check(ovw_flag == 1'b1, "R9 flag sticky", ovw_flag, 1);

        // R8: boundary hit on the next-packet page
        bnd_page = 8'h4F;
        d0 = done_cnt; o0 = ovw_cnt;
        send_pkt(5, 8'h33, 67);
        check(cur_page == 8'h4E, "R8 cur kept", cur_page, 8'h4E);
        check(ovw_cnt - o0 == 1, "R8 ovw pulse", ovw_cnt - o0, 1);
        check(done_cnt - d0 == 0, "R8 no commit", done_cnt - d0, 0);

        // R9: clear
        @(posedge clk); #1;
        ovw_clr = 1'b1;
        @(posedge clk); #1;
        ovw_clr = 1'b0;
        @(negedge clk);
        check(ovw_flag == 1'b0, "R9 flag cleared", ovw_flag, 0);

        // R11: bytes without a start in IDLE are ignored
        bnd_page = 8'h70;
        d0 = done_cnt;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            rx_valid = 1'b1;
            rx_eop   = (i == 2);
            rx_data  = 8'hA5;
        end
        @(posedge clk); #1;
        rx_valid = 1'b0;
        rx_eop   = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(cur_page == 8'h4E, "R11 cur unchanged", cur_page, 8'h4E);
        check(done_cnt - d0 == 0, "R11 no commit", done_cnt - d0, 0);

        // R10: empty again when boundary is just behind current
        bnd_page = 8'h4D;
        #1;
        check(ring_empty == 1'b1, "R10 empty", ring_empty, 1);

        check(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule